// File: doc/BRIEF.md
# Buzzer Tone and Alarm Envelope Generator

This block drives a complementary buzzer pair from a programmable tone. An 8-bit down-counter divides either the system clock or a slow base tick into equal steps. A shaper turns those steps into a pulse train that is high for one step out of two, three or four. An envelope stage then chooses what reaches the pins: the tone itself, a steady level, the tone gated by one of three fast prescaler levels, or silence. A 6-bit mask can also hold the output quiet unless selected slow prescaler levels are all high, which lets software build beep-and-pause patterns without touching the tone setting.

Software writes the tone settings through one strobe and the envelope settings through a second strobe. Tone settings are staged and take effect only when the current step ends, so a change made while a note is playing never produces a short or stretched pulse. The prescaler is outside this block. Its stage levels arrive as a plain 16-bit vector, with bit k carrying stage k.

Top module: `buzz_alarm_gen`

## Requirements
- R1: After reset both outputs are low, the envelope code is 000 and the mask is 0. The staged tone settings are divider value 0, duty code 00 and system-clock source, so with envelope 111 the output is high 1 cycle out of every 4.
- R2: With the system-clock source and divider value D, every step lasts exactly D+1 clock cycles, for any D from 0 to 255.
- R3: Source bit tone_fast=1 counts every clock cycle. With tone_fast=0 the counter advances only in cycles where base_tick is high, so a step lasts D+1 base ticks.
- R4: Duty code 00 gives a period of 4 steps, 01 gives 3 steps, and 10 or 11 gives 2 steps. The tone is high for the first step of each period and low for the rest.
- R5: Divider value, duty and source written during a step are held until that step ends. The step in progress completes at its old length and the new values govern the next step.
- R6: Envelope code 111 passes the tone. Code 100 holds bz high and bzb low. Codes 000, 101 and 110 hold both outputs low.
- R7: Envelope code 011 passes the tone only while prescaler level 3 is high. Code 010 uses level 4 and code 001 uses level 5. While the selected level is low, both outputs are low.
- R8: Mask bit i (0 to 5) enables gating by prescaler level 10+i. The output is active only while every enabled level is high; otherwise both outputs are low. A mask of 0 never blocks.
- R9: While the output is active, bzb is the inverse of bz. The two are never high together.
- R10: Both outputs are registered. A change of a prescaler level shows at the pins after the next clock edge. A written envelope setting shows one edge after the write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Slow base tick strobe, used as the divider clock when tone_fast=0 |
| pre_lvl | input | 16 | Prescaler stage levels, bit k is stage k |
| tone_we | input | 1 | Write strobe for tone settings |
| tone_div | input | 8 | Divider value D; a step lasts D+1 counts |
| tone_duty | input | 2 | Duty code: 00 = 1/4, 01 = 1/3, 10 and 11 = 1/2 |
| tone_fast | input | 1 | Divider source: 1 = system clock, 0 = base_tick |
| env_we | input | 1 | Write strobe for envelope settings |
| env_sel | input | 3 | Envelope code (see R6, R7) |
| env_mask | input | 6 | Slow-level gating mask, bit i selects level 10+i |
| bz | output | 1 | Buzzer drive |
| bzb | output | 1 | Complementary buzzer drive |

## Verification
The bench sweeps divider values 0 to 15 against all four duty codes and also tries the largest divider value. It measures high time and period at the pins. An off-by-one in the reload would show as periods of D steps instead of D+1, and a wrong duty decode would give the wrong count of low steps. The base-tick source is timed with ticks spaced several cycles apart, which exposes a counter that ignores the strobe. A mid-step rewrite checks that the running step keeps its old length: a design that reloads at once would cut the pulse short. Each envelope code, each fast tap and each mask bit is taken in turn with its controlling level high and then low. A one-edge latency check catches an extra or missing pipeline stage.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

  typedef enum logic [1:0] {
    DUTY_QUARTER  = 2'b00,
    DUTY_THIRD    = 2'b01,
    DUTY_HALF     = 2'b10,
    DUTY_HALF_ALT = 2'b11
  } duty_e;

  typedef enum logic [2:0] {
    ENV_SILENT   = 3'b000,
    ENV_TAP_SLOW = 3'b001,
    ENV_TAP_MID  = 3'b010,
    ENV_TAP_FAST = 3'b011,
    ENV_STEADY   = 3'b100,
    ENV_RSV_A    = 3'b101,
    ENV_RSV_B    = 3'b110,
    ENV_TONE     = 3'b111
  } env_e;

  // index of the last step in one tone period
  function automatic logic [1:0] last_step(input duty_e d);
    case (d)
      DUTY_QUARTER: last_step = 2'd3;
      DUTY_THIRD:   last_step = 2'd2;
      default:      last_step = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/buzz_step_div.sv
module buzz_step_div
  import buzz_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_tick,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_duty,
  input  logic             cfg_fast,
  output logic             step,
  output duty_e            step_duty
);

  logic [DIV_W-1:0] pend_div;
  duty_e            pend_duty;
  logic             pend_fast;
  logic             run_fast;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_en;

  assign tick_en   = run_fast | base_tick;
  assign step      = tick_en && (cnt_q == '0);
  assign step_duty = pend_duty;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_div  <= '0;
      pend_duty <= DUTY_QUARTER;
      pend_fast <= 1'b1;
    end else if (cfg_we) begin
      pend_div  <= cfg_div;
      pend_duty <= duty_e'(cfg_duty);
      pend_fast <= cfg_fast;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      run_fast <= 1'b1;
    end else if (step) begin
      cnt_q    <= pend_div;
      run_fast <= pend_fast;
    end else if (tick_en) begin
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_fast && !base_tick) |=> $stable(cnt_q));

  // R5
  source_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(run_fast));

endmodule

// File: rtl/buzz_duty_shaper.sv
module buzz_duty_shaper
  import buzz_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  input  duty_e duty,
  output logic  tone
);

  logic [1:0] phase_q;
  logic [1:0] lim;

  assign lim  = last_step(duty);
  assign tone = (phase_q == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 2'd0;
    end else if (step) begin
      phase_q <= (phase_q >= lim) ? 2'd0 : phase_q + 2'd1;
    end
  end

  // R4
  phase_moves_on_step_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase_q));

  // R4
  half_duty_range_chk: assert property (@(posedge clk) disable iff (rst)
    (step && (duty == DUTY_HALF)) |=> (phase_q <= 2'd1));

endmodule

// File: rtl/buzz_env_gate.sv
module buzz_env_gate
  import buzz_pkg::*;
#(
  parameter int PRE_W    = 16,
  parameter int MASK_W   = 6,
  parameter int MASK_LSB = 10,
  parameter int TAP_LO   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              env_we,
  input  logic [2:0]        env_sel,
  input  logic [MASK_W-1:0] env_mask,
  input  logic [PRE_W-1:0]  pre_lvl,
  input  logic              tone,
  output logic              bz,
  output logic              bzb
);

  localparam int TAP_FAST_IX = TAP_LO;
  localparam int TAP_MID_IX  = TAP_LO + 1;
  localparam int TAP_SLOW_IX = TAP_LO + 2;

  env_e              sel_q;
  logic [MASK_W-1:0] mask_q;
  logic              mask_ok;
  logic              gate;
  logic              src_hi;
  logic              bz_q;
  logic              bzb_q;
  logic              pre_unused;

  assign pre_unused = ^pre_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= ENV_SILENT;
      mask_q <= '0;
    end else if (env_we) begin
      sel_q  <= env_e'(env_sel);
      mask_q <= env_mask;
    end
  end

  assign mask_ok = &(~mask_q | pre_lvl[MASK_LSB +: MASK_W]);

  always_comb begin
    case (sel_q)
      ENV_TONE,
      ENV_STEADY:   gate = 1'b1;
      ENV_TAP_FAST: gate = pre_lvl[TAP_FAST_IX];
      ENV_TAP_MID:  gate = pre_lvl[TAP_MID_IX];
      ENV_TAP_SLOW: gate = pre_lvl[TAP_SLOW_IX];
      default:      gate = 1'b0;
    endcase
  end

  assign src_hi = (sel_q == ENV_STEADY) | tone;

  always_ff @(posedge clk) begin
    if (rst) begin
      bz_q  <= 1'b0;
      bzb_q <= 1'b0;
    end else begin
      bz_q  <= gate & mask_ok & src_hi;
      bzb_q <= gate & mask_ok & ~src_hi;
    end
  end

  assign bz  = bz_q;
  assign bzb = bzb_q;

  // R9
  never_both_high_chk: assert property (@(posedge clk) disable iff (rst)
    !(bz_q && bzb_q));

  // R6
  silent_code_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == ENV_SILENT) |=> (!bz_q && !bzb_q));

  // R6
  steady_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((sel_q == ENV_STEADY) && mask_ok) |=> (bz_q && !bzb_q));

  // R8
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_ok |=> (!bz_q && !bzb_q));

endmodule

// File: rtl/buzz_alarm_gen.sv
module buzz_alarm_gen
  import buzz_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_W    = 16,
  parameter int MASK_W   = 6,
  parameter int MASK_LSB = 10,
  parameter int TAP_LO   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic [PRE_W-1:0]  pre_lvl,
  input  logic              tone_we,
  input  logic [DIV_W-1:0]  tone_div,
  input  logic [1:0]        tone_duty,
  input  logic              tone_fast,
  input  logic              env_we,
  input  logic [2:0]        env_sel,
  input  logic [MASK_W-1:0] env_mask,
  output logic              bz,
  output logic              bzb
);

  logic  step;
  duty_e step_duty;
  logic  tone;

  buzz_step_div #(
    .DIV_W(DIV_W)
  ) i_div (
    .clk       (clk),
    .rst       (rst),
    .base_tick (base_tick),
    .cfg_we    (tone_we),
    .cfg_div   (tone_div),
    .cfg_duty  (tone_duty),
    .cfg_fast  (tone_fast),
    .step      (step),
    .step_duty (step_duty)
  );

  buzz_duty_shaper i_shape (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .duty (step_duty),
    .tone (tone)
  );

  buzz_env_gate #(
    .PRE_W    (PRE_W),
    .MASK_W   (MASK_W),
    .MASK_LSB (MASK_LSB),
    .TAP_LO   (TAP_LO)
  ) i_env (
    .clk      (clk),
    .rst      (rst),
    .env_we   (env_we),
    .env_sel  (env_sel),
    .env_mask (env_mask),
    .pre_lvl  (pre_lvl),
    .tone     (tone),
    .bz       (bz),
    .bzb      (bzb)
  );

endmodule

// File: tb/test_buzz_alarm_gen.sv
`timescale 1ns/1ps
module test_buzz_alarm_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        base_tick;
  logic [15:0] pre_lvl;
  logic        tone_we;
  logic [7:0]  tone_div;
  logic [1:0]  tone_duty;
  logic        tone_fast;
  logic        env_we;
  logic [2:0]  env_sel;
  logic [5:0]  env_mask;
  logic        bz;
  logic        bzb;

  int total = 0;
  int bad   = 0;
  int tick_k = 1;

  always #2.5 clk = ~clk;

  buzz_alarm_gen i_buzz_alarm_gen (
    .clk(clk), .rst(rst), .base_tick(base_tick), .pre_lvl(pre_lvl),
    .tone_we(tone_we), .tone_div(tone_div), .tone_duty(tone_duty),
    .tone_fast(tone_fast), .env_we(env_we), .env_sel(env_sel),
    .env_mask(env_mask), .bz(bz), .bzb(bzb)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // base tick generator: one pulse every tick_k cycles
  initial begin
    int ph;
    ph = 0;
    base_tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (ph >= tick_k - 1) begin
        base_tick = 1'b1;
        ph = 0;
      end else begin
        base_tick = 1'b0;
        ph = ph + 1;
      end
    end
  end

  task automatic set_tone(input int d, input int duty, input bit fast);
    tone_div = 8'(d); tone_duty = 2'(duty); tone_fast = fast; tone_we = 1'b1;
    tick;
    tone_we = 1'b0;
  endtask

  task automatic set_env(input int sel, input int mask);
    env_sel = 3'(sel); env_mask = 6'(mask); env_we = 1'b1;
    tick;
    env_we = 1'b0;
  endtask

  // leaves the bench at a sample where bz has just risen
  task automatic sync_rise;
    bit prev;
    prev = bz;
    tick;
    while (!(!prev && bz)) begin
      prev = bz;
      tick;
    end
  endtask

  // starts at a rise sample, ends at the next rise sample
  task automatic measure(output int hi, output int per);
    hi = 1; per = 1;
    tick;
    while (bz) begin hi++; per++; tick; end
    while (!bz) begin per++; tick; end
  endtask

  task automatic settle_measure(output int hi, output int per);
    int h0, p0;
    sync_rise;
    measure(h0, p0);
    measure(hi, per);
  endtask

  task automatic win(input int n, output int nbz, output int nsil, output int ncomp);
    nbz = 0; nsil = 0; ncomp = 0;
    for (int i = 0; i < n; i++) begin
      tick;
      if (bz) nbz++;
      if (!bz && !bzb) nsil++;
      if (bz != bzb) ncomp++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, per, nsteps, nbz, nsil, ncomp, lo, k;
    rst = 1'b1; pre_lvl = 16'hFFFF; tone_we = 1'b0; tone_div = '0;
    tone_duty = '0; tone_fast = 1'b1; env_we = 1'b0; env_sel = '0; env_mask = '0;
    repeat (4) tick;
    rst = 1'b0;
    tick;
    // R1 reset state at the pins
    chk(!bz && !bzb, "R1 outputs low after reset", {bz, bzb}, 0);
    win(8, nbz, nsil, ncomp);
    chk(nsil == 8, "R1 silent envelope after reset", nsil, 8);
    set_env(7, 0);
    settle_measure(hi, per);
    chk(hi == 1, "R1 default high time", hi, 1);
    chk(per == 4, "R1 default period", per, 4);

    // R2 / R4 sweep of divider value and duty code, system clock
    for (int duty = 0; duty < 4; duty++) begin
      for (int d = 0; d < 16; d++) begin
        set_tone(d, duty, 1'b1);
        settle_measure(hi, per);
        nsteps = (duty == 0) ? 4 : (duty == 1) ? 3 : 2;
        chk(hi == d + 1, "R2 step length", hi, d + 1);
        chk(per == nsteps * (d + 1), "R4 period by duty", per, nsteps * (d + 1));
      end
    end
    set_tone(255, 2, 1'b1);
    settle_measure(hi, per);
    chk(hi == 256, "R2 largest divider high", hi, 256);
    chk(per == 512, "R2 largest divider period", per, 512);

    // R3 base tick source
    tick_k = 3;
    set_tone(4, 1, 1'b0);
    settle_measure(hi, per);
    chk(hi == 15, "R3 base tick high", hi, 15);
    chk(per == 45, "R3 base tick period", per, 45);
    tick_k = 5;
    set_tone(2, 0, 1'b0);
    settle_measure(hi, per);
    chk(hi == 15, "R3 base tick high k5", hi, 15);
    chk(per == 60, "R3 base tick period k5", per, 60);
    set_tone(9, 2, 1'b1);
    tick_k = 1;

    // R5 rewrite during a step
    settle_measure(hi, per);
    hi = 1; k = 0;
    do begin
      tone_div = 8'd2; tone_duty = 2'd2; tone_fast = 1'b1;
      tone_we = (k == 3);
      tick;
      tone_we = 1'b0;
      k++;
      if (bz) hi++;
    end while (bz);
    chk(hi == 10, "R5 running step keeps old length", hi, 10);
    lo = 1;
    tick;
    while (!bz) begin lo++; tick; end
    chk(lo == 3, "R5 next step uses new value", lo, 3);
    measure(hi, per);
    chk(hi == 3 && per == 6, "R5 new period", per, 6);

    // R6 envelope codes, tone high 2 low 2
    set_tone(1, 2, 1'b1);
    settle_measure(hi, per);
    for (int s = 0; s < 8; s++) begin
      if (s == 0 || s == 5 || s == 6) begin
        set_env(s, 0); tick;
        win(16, nbz, nsil, ncomp);
        chk(nsil == 16, "R6 silent code", nsil, 16);
      end
    end
    set_env(4, 0); tick;
    win(16, nbz, nsil, ncomp);
    chk(nbz == 16 && ncomp == 16, "R6 steady code", nbz, 16);
    set_env(7, 0); tick;
    win(16, nbz, nsil, ncomp);
    chk(nbz == 8, "R6 tone code passes tone", nbz, 8);
    chk(ncomp == 16, "R9 complementary while active", ncomp, 16);

    // R7 fast tap gating
    for (int s = 1; s < 4; s++) begin
      int b;
      b = 3 + (3 - s);
      pre_lvl = 16'(1) << b;
      set_env(s, 0); tick;
      win(16, nbz, nsil, ncomp);
      chk(nbz == 8 && ncomp == 16, "R7 tap high passes tone", nbz, 8);
      pre_lvl = 16'hFFFF ^ (16'(1) << b);
      tick; tick;
      win(16, nbz, nsil, ncomp);
      chk(nsil == 16, "R7 tap low silences", nsil, 16);
    end
    pre_lvl = 16'hFFFF;

    // R8 mask bits with steady code, R10 one-edge latency
    for (int i = 0; i < 6; i++) begin
      set_env(4, 1 << i); tick;
      chk(bz && !bzb, "R8 enabled level high passes", bz, 1);
      pre_lvl[10 + i] = 1'b0;
      tick;
      chk(!bz && !bzb, "R10 mask level low after one edge", bz, 0);
      tick;
      chk(!bz && !bzb, "R8 enabled level low blocks", bz, 0);
      pre_lvl = 16'hFFFF;
    end
    pre_lvl = 16'hFFFF ^ 16'h0400;
    set_env(4, 6'h3E); tick;
    chk(bz, "R8 disabled bit ignored", bz, 1);
    pre_lvl = 16'h0000;
    set_env(4, 0); tick;
    chk(bz && !bzb, "R8 zero mask never blocks", bz, 1);
    pre_lvl = 16'hFFFF;

    // R10 envelope write latency
    set_env(0, 0); tick;
    env_sel = 3'd4; env_mask = 6'd0; env_we = 1'b1;
    tick;
    env_we = 1'b0;
    chk(!bz, "R10 not yet after capture edge", bz, 0);
    tick;
    chk(bz && !bzb, "R10 output one edge later", bz, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule